// File: doc/BRIEF.md
# Interlocked Four-Way Mesh Port with Multicast

This block is the network edge of one tile in a statically routed two-dimensional mesh. The tile has four neighbours: north, east, south and west. For each neighbour it keeps a one-word receive slot and a one-word send slot. Every slot is exactly one entry deep and uses a valid/ready handshake. No routing decision is made in hardware. Words move only when the tile's current instruction tells them to.

On each cycle the instruction may do three things. It may name one receive slot as an operand. It may name any subset of the send slots as destinations. It chooses whether the destinations get the received word or the externally computed result. When the instruction leaves the network untouched, a separate move field can forward a received word to a set of send slots in the same cycle.

The block raises a stall when the instruction cannot complete. That happens when the operand slot is empty or any destination slot is occupied. A stalled instruction changes nothing. The arithmetic unit lies outside the block; only its result word enters here.

Top module: `mesh_port`

## Requirements
- R1: After a synchronous active-high reset, every receive slot is empty (`in_ready` = 4'b1111), every send slot is empty (`out_valid` = 4'b0000) and `stall` is low.
- R2: A receive slot takes a word on a clock edge where `in_valid` and `in_ready` of that direction are both high. Its `in_ready` then stays low until the word is consumed.
- R3: Direction codes are 0 = north, 1 = east, 2 = south, 3 = west. `rd_data` shows, in the same cycle, the word held in the receive slot selected by the active operand select.
- R4: Output mask bit 0 is north, bit 1 east, bit 2 south and bit 3 west. When the instruction completes, every send slot whose bit is set holds the same word, with `out_valid` high, from the next cycle on.
- R5: With `op_from_alu` = 1 the sent word is `alu_result`. With `op_from_alu` = 0 it is the selected received word.
- R6: With `op_valid` high, `stall` is high exactly when an operand is enabled and its slot is empty, or when any masked send slot is occupied.
- R7: A stalled instruction writes no send slot, not even the free ones in its mask, and consumes no received word.
- R8: A received word is consumed only when an instruction completes with its operand enabled and that direction selected. With `op_use_in` = 0 the slot keeps its word whatever `op_in_sel` holds.
- R9: When `op_use_in` = 0 and `op_out_mask` = 0, a set `mv_en` moves the word from receive slot `mv_in_sel` to the send slots in `mv_out_mask` and consumes it. When the main instruction uses the network, the move fields are ignored.
- R10: With `op_valid` low, `stall` is low and no slot is read or written.
- R11: A send slot holds its word until `out_ready` is high with `out_valid`. It is empty on the next cycle and can then be written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Neighbour offers a word, one bit per direction |
| in_data | input | 4xW | Offered words, one per direction |
| in_ready | output | 4 | Receive slot is empty |
| out_valid | output | 4 | Send slot holds a word |
| out_data | output | 4xW | Words held in the send slots |
| out_ready | input | 4 | Neighbour takes the send slot word |
| op_valid | input | 1 | An instruction is present this cycle |
| op_use_in | input | 1 | Instruction reads a receive slot |
| op_in_sel | input | 2 | Direction of the operand slot |
| op_out_mask | input | 4 | Destination send slots |
| op_from_alu | input | 1 | 1: send alu_result, 0: send the received word |
| alu_result | input | W | Computed result word |
| mv_en | input | 1 | Enable the side move |
| mv_in_sel | input | 2 | Source direction of the side move |
| mv_out_mask | input | 4 | Destinations of the side move |
| rd_data | output | W | Selected received word, fed to the arithmetic unit |
| stall | output | 1 | Instruction cannot complete this cycle |

## Verification
The hardest case to reach is a partly blocked multicast. In that case some masked send slots are free and others are occupied, while the operand slot is full or empty in various combinations. To set it up, each vector first resets the block. It then parks a known word in chosen send slots by completing a result-only write while `out_ready` stays low. Next it fills chosen receive slots, and only then issues the instruction under test. Because the bench sets the slot state this way, it can show that a stall leaves the free destinations empty and the operand word in place. The side-move ignore case is set up the same way: the chosen source slot is preloaded, so any wrongly executed move would show up at the send ports.

// File: rtl/mesh_port_pkg.sv
package mesh_port_pkg;

    localparam int NDIR = 4;
    localparam int SELW = $clog2(NDIR);

    typedef enum logic [SELW-1:0] {
        DIR_N = 2'd0,
        DIR_E = 2'd1,
        DIR_S = 2'd2,
        DIR_W = 2'd3
    } dir_e;

    typedef struct packed {
        logic            use_in;
        logic [SELW-1:0] in_sel;
        logic [NDIR-1:0] out_mask;
        logic            from_alu;
    } net_op_t;

    function automatic logic [NDIR-1:0] dir_bit(input logic [SELW-1:0] s);
        return NDIR'(1) << s;
    endfunction

endpackage

// File: rtl/mp_slot.sv
module mp_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         full,
    output logic [W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (push) begin
            full <= 1'b1;
            data <= push_data;
        end else if (pop) begin
            full <= 1'b0;
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    assert_pop_occupied_R11: assert property (@(posedge clk) disable iff (rst)
        pop |-> full);

endmodule

// File: rtl/mp_interlock.sv
module mp_interlock
    import mesh_port_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  net_op_t         main_op,
    input  logic            mv_en,
    input  logic [SELW-1:0] mv_sel,
    input  logic [NDIR-1:0] mv_mask,
    input  logic [NDIR-1:0] in_full,
    input  logic [NDIR-1:0] out_full,
    output net_op_t         eff_op,
    output logic            stall,
    output logic            fire,
    output logic [NDIR-1:0] pop_in,
    output logic [NDIR-1:0] push_out
);

    logic main_uses_net;
    logic in_miss;
    logic out_block;

    always_comb begin
        main_uses_net = main_op.use_in | (|main_op.out_mask);
        if (main_uses_net || !mv_en) begin
            eff_op = main_op;
        end else begin
            eff_op.use_in   = 1'b1;
            eff_op.in_sel   = mv_sel;
            eff_op.out_mask = mv_mask;
            eff_op.from_alu = 1'b0;
        end
    end

    assign in_miss   = eff_op.use_in & ~in_full[eff_op.in_sel];
    assign out_block = |(eff_op.out_mask & out_full);
    assign stall     = op_valid & (in_miss | out_block);
    assign fire      = op_valid & ~stall;
    assign pop_in    = (fire && eff_op.use_in) ? dir_bit(eff_op.in_sel) : '0;
    assign push_out  = fire ? eff_op.out_mask : '0;

    assert_single_pop_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pop_in));

    assert_pop_needs_word_R6: assert property (@(posedge clk) disable iff (rst)
        |(pop_in & ~in_full) == 1'b0);

    assert_no_write_on_stall_R7: assert property (@(posedge clk) disable iff (rst)
        stall |-> (push_out == '0 && pop_in == '0));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> (!stall && push_out == '0 && pop_in == '0));

endmodule

// File: rtl/mesh_port.sv
module mesh_port
    import mesh_port_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NDIR-1:0]          in_valid,
    input  logic [NDIR-1:0][W-1:0]   in_data,
    output logic [NDIR-1:0]          in_ready,
    output logic [NDIR-1:0]          out_valid,
    output logic [NDIR-1:0][W-1:0]   out_data,
    input  logic [NDIR-1:0]          out_ready,
    input  logic                     op_valid,
    input  logic                     op_use_in,
    input  logic [SELW-1:0]          op_in_sel,
    input  logic [NDIR-1:0]          op_out_mask,
    input  logic                     op_from_alu,
    input  logic [W-1:0]             alu_result,
    input  logic                     mv_en,
    input  logic [SELW-1:0]          mv_in_sel,
    input  logic [NDIR-1:0]          mv_out_mask,
    output logic [W-1:0]             rd_data,
    output logic                     stall
);

    net_op_t               main_op;
    net_op_t               eff_op;
    logic                  fire;
    logic [NDIR-1:0]       in_full;
    logic [NDIR-1:0]       out_full;
    logic [NDIR-1:0]       pop_in;
    logic [NDIR-1:0]       push_out;
    logic [NDIR-1:0][W-1:0] in_q;
    logic [W-1:0]          send_word;

    assign main_op.use_in   = op_use_in;
    assign main_op.in_sel   = op_in_sel;
    assign main_op.out_mask = op_out_mask;
    assign main_op.from_alu = op_from_alu;

    mp_interlock u_lock (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .main_op  (main_op),
        .mv_en    (mv_en),
        .mv_sel   (mv_in_sel),
        .mv_mask  (mv_out_mask),
        .in_full  (in_full),
        .out_full (out_full),
        .eff_op   (eff_op),
        .stall    (stall),
        .fire     (fire),
        .pop_in   (pop_in),
        .push_out (push_out)
    );

    assign rd_data   = in_q[eff_op.in_sel];
    assign send_word = eff_op.from_alu ? alu_result : rd_data;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        mp_slot #(.W(W)) u_rx (
            .clk       (clk),
            .rst       (rst),
            .push      (in_valid[d] & ~in_full[d]),
            .push_data (in_data[d]),
            .pop       (pop_in[d]),
            .full      (in_full[d]),
            .data      (in_q[d])
        );

        mp_slot #(.W(W)) u_tx (
            .clk       (clk),
            .rst       (rst),
            .push      (push_out[d]),
            .push_data (send_word),
            .pop       (out_full[d] & out_ready[d]),
            .full      (out_full[d]),
            .data      (out_data[d])
        );

        assign in_ready[d]  = ~in_full[d];
        assign out_valid[d] = out_full[d];

        assert_mcast_land_R4: assert property (@(posedge clk) disable iff (rst)
            (fire && eff_op.out_mask[d]) |=> out_valid[d]);

        assert_alu_source_R5: assert property (@(posedge clk) disable iff (rst)
            (fire && eff_op.out_mask[d] && eff_op.from_alu)
                |=> out_data[d] == $past(alu_result));

        assert_free_stays_free_R7: assert property (@(posedge clk) disable iff (rst)
            (stall && !out_full[d]) |=> !out_full[d]);

        assert_word_kept_R7: assert property (@(posedge clk) disable iff (rst)
            (stall && in_full[d]) |=> in_full[d]);
    end

endmodule

// File: tb/test_mesh_port.sv
module test_mesh_port;
    import mesh_port_pkg::*;

    localparam int W = 32;
    localparam logic [W-1:0] PARK = 32'hAAAA_0000;
    localparam int NV = 10;
    // {in_fill[3:0], out_fill[3:0], use_in, sel[1:0], mask[3:0], from_alu}
    localparam logic [15:0] VEC [NV] = '{
        {4'hF, 4'h0, 1'b1, 2'd0, 4'b1111, 1'b0},
        {4'hF, 4'h0, 1'b1, 2'd2, 4'b0101, 1'b1},
        {4'h0, 4'h0, 1'b1, 2'd1, 4'b0010, 1'b0},
        {4'hF, 4'h2, 1'b1, 2'd3, 4'b0011, 1'b1},
        {4'h2, 4'h0, 1'b0, 2'd1, 4'b1000, 1'b1},
        {4'h4, 4'h8, 1'b1, 2'd2, 4'b0001, 1'b0},
        {4'hF, 4'hF, 1'b0, 2'd0, 4'b0000, 1'b1},
        {4'h8, 4'h0, 1'b1, 2'd3, 4'b1100, 1'b0},
        {4'h1, 4'h0, 1'b1, 2'd0, 4'b0000, 1'b1},
        {4'hF, 4'h1, 1'b1, 2'd1, 4'b1111, 1'b0}
    };

    logic                   clk = 1'b0;
    logic                   rst;
    logic [NDIR-1:0]        in_valid;
    logic [NDIR-1:0][W-1:0] in_data;
    logic [NDIR-1:0]        in_ready;
    logic [NDIR-1:0]        out_valid;
    logic [NDIR-1:0][W-1:0] out_data;
    logic [NDIR-1:0]        out_ready;
    logic                   op_valid;
    logic                   op_use_in;
    logic [SELW-1:0]        op_in_sel;
    logic [NDIR-1:0]        op_out_mask;
    logic                   op_from_alu;
    logic [W-1:0]           alu_result;
    logic                   mv_en;
    logic [SELW-1:0]        mv_in_sel;
    logic [NDIR-1:0]        mv_out_mask;
    logic [W-1:0]           rd_data;
    logic                   stall;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    mesh_port #(.W(W)) i_mesh_port (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .op_valid(op_valid), .op_use_in(op_use_in), .op_in_sel(op_in_sel),
        .op_out_mask(op_out_mask), .op_from_alu(op_from_alu),
        .alu_result(alu_result), .mv_en(mv_en), .mv_in_sel(mv_in_sel),
        .mv_out_mask(mv_out_mask), .rd_data(rd_data), .stall(stall)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        in_valid = '0; out_ready = '0; op_valid = 1'b0; op_use_in = 1'b0;
        op_in_sel = '0; op_out_mask = '0; op_from_alu = 1'b0; alu_result = '0;
        mv_en = 1'b0; mv_in_sel = '0; mv_out_mask = '0;
        for (int d = 0; d < NDIR; d++) in_data[d] = 32'h100 + d;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic park_and_fill(input logic [3:0] outm, input logic [3:0] inm);
        if (outm != 0) begin
            op_valid = 1'b1; op_out_mask = outm; op_from_alu = 1'b1; alu_result = PARK;
            tick();
            op_valid = 1'b0; op_out_mask = '0;
        end
        if (inm != 0) begin
            in_valid = inm;
            tick();
            in_valid = '0;
        end
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        #1;
        chk(in_ready == 4'hF, "R1 in_ready", in_ready, 4'hF);
        chk(out_valid == 4'h0, "R1 out_valid", out_valid, 0);
        chk(stall == 1'b0, "R1 stall", stall, 0);

        for (int k = 0; k < NV; k++) begin
            logic [3:0] inm, outm, mask, exp_ov, exp_ir;
            logic use_i, src, exp_st;
            logic [1:0] sel;
            logic [W-1:0] alu_k, exp_d;
            {inm, outm, use_i, sel, mask, src} = VEC[k];
            alu_k  = 32'hC0DE_0000 + k;
            exp_st = (use_i & ~inm[sel]) | (|(mask & outm));
            do_reset();
            park_and_fill(outm, inm);
            // R2: filled slots refuse further words
            chk(in_ready == ~inm, "R2 in_ready after fill", in_ready, ~inm);
            op_valid = 1'b1; op_use_in = use_i; op_in_sel = sel;
            op_out_mask = mask; op_from_alu = src; alu_result = alu_k;
            #1;
            chk(stall == exp_st, "R6 stall", stall, exp_st);
            if (use_i && inm[sel])
                chk(rd_data == 32'h100 + sel, "R3 rd_data", rd_data, 32'h100 + sel);
            tick();
            op_valid = 1'b0;
            exp_ov = exp_st ? outm : (outm | mask);
            exp_ir = ~inm;
            if (!exp_st && use_i) exp_ir[sel] = 1'b1;
            chk(out_valid == exp_ov, exp_st ? "R7 out_valid" : "R4 out_valid", out_valid, exp_ov);
            chk(in_ready == exp_ir, exp_st ? "R7 in_ready" : "R8 in_ready", in_ready, exp_ir);
            for (int d = 0; d < NDIR; d++) begin
                if (exp_ov[d]) begin
                    if (outm[d]) exp_d = PARK;
                    else if (src) exp_d = alu_k;
                    else exp_d = 32'h100 + sel;
                    chk(out_data[d] == exp_d, "R5 out_data", out_data[d], exp_d);
                end
            end
        end

        // R11: drain then rewrite
        do_reset();
        park_and_fill(4'b0100, 4'h0);
        chk(out_valid == 4'b0100, "R11 held", out_valid, 4'b0100);
        tick();
        chk(out_valid == 4'b0100, "R11 held without ready", out_valid, 4'b0100);
        out_ready = 4'b0100;
        tick();
        out_ready = '0;
        chk(out_valid == 4'b0000, "R11 drained", out_valid, 0);
        op_valid = 1'b1; op_out_mask = 4'b0100; op_from_alu = 1'b1; alu_result = 32'h55;
        #1;
        chk(stall == 1'b0, "R11 rewrite no stall", stall, 0);
        tick();
        op_valid = 1'b0;
        chk(out_valid == 4'b0100 && out_data[2] == 32'h55, "R11 rewrite", out_data[2], 32'h55);

        // R9: side move when main uses no network
        do_reset();
        park_and_fill(4'h0, 4'b0001);
        op_valid = 1'b1; op_from_alu = 1'b1; alu_result = 32'h77;
        mv_en = 1'b1; mv_in_sel = 2'd0; mv_out_mask = 4'b0110;
        #1;
        chk(stall == 1'b0, "R9 move no stall", stall, 0);
        tick();
        op_valid = 1'b0; mv_en = 1'b0;
        chk(out_valid == 4'b0110, "R9 move dest", out_valid, 4'b0110);
        chk(out_data[1] == 32'h100 && out_data[2] == 32'h100, "R9 move word", out_data[1], 32'h100);
        chk(in_ready[0] == 1'b1, "R9 move consumes", in_ready[0], 1);

        // R9: move ignored when main writes the network
        do_reset();
        park_and_fill(4'h0, 4'b0001);
        op_valid = 1'b1; op_out_mask = 4'b0001; op_from_alu = 1'b1; alu_result = 32'h99;
        mv_en = 1'b1; mv_in_sel = 2'd0; mv_out_mask = 4'b1000;
        tick();
        op_valid = 1'b0; mv_en = 1'b0; op_out_mask = '0;
        chk(out_valid == 4'b0001, "R9 move ignored dest", out_valid, 4'b0001);
        chk(out_data[0] == 32'h99, "R9 main word", out_data[0], 32'h99);
        chk(in_ready[0] == 1'b0, "R9 move ignored keeps input", in_ready[0], 0);

        // R10: idle instruction with blocking fields
        do_reset();
        park_and_fill(4'b0010, 4'h0);
        op_valid = 1'b0; op_use_in = 1'b1; op_in_sel = 2'd3; op_out_mask = 4'b1111;
        #1;
        chk(stall == 1'b0, "R10 no stall", stall, 0);
        tick();
        chk(out_valid == 4'b0010, "R10 no write", out_valid, 4'b0010);
        chk(in_ready == 4'hF, "R10 no read", in_ready, 4'hF);

        // R2: a word offered to a full slot is not taken
        do_reset();
        in_data[3] = 32'hBEEF; in_valid = 4'b1000;
        tick();
        in_data[3] = 32'hDEAD;
        tick();
        in_valid = '0;
        op_valid = 1'b1; op_use_in = 1'b1; op_in_sel = 2'd3; op_out_mask = 4'b0001;
        op_from_alu = 1'b0;
        #1;
        chk(rd_data == 32'hBEEF, "R2 first word kept", rd_data, 32'hBEEF);
        tick();
        op_valid = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule